// File: doc/BRIEF.md
# Converter Host Read Port with Byte Lane Multiplexing

This block is the host-facing side of a 12-bit successive-approximation converter. A host reaches the converter through three control pins: an active-low select, an active-low read strobe and an active-high byte selector. A read access with the byte selector low returns the low byte, or the whole word on a wide bus, and also asks the sequencer for a new conversion. A read with the byte selector high returns only the top bits and never starts anything. The result word itself lives in the sequencer; this block only decides what is put on the bus and when.

The control pins are asynchronous to the block clock. They pass through a reset-aware synchronizer, are decoded into an access type and drive a four-state machine. The states are ST_IDLE (no access), ST_LAUNCH (the single cycle in which the start strobe is raised), ST_LO_READ (low-byte or full-word read in progress) and ST_HI_READ (high-byte read in progress). From ST_IDLE or ST_HI_READ, a low-byte access goes to ST_LAUNCH when the sequencer is idle, or straight to ST_LO_READ when it is busy. ST_LAUNCH always leaves after one cycle, to ST_LO_READ if the access is still a low-byte read. Any state goes to ST_HI_READ on a high-byte access and to ST_IDLE when no access is decoded. The bus is modelled as an enable plus a data word that is zero whenever the enable is low.

Top module: `conv_bus_if`

## Requirements
- R1: While reset is asserted and on the first cycles after it, conv_start and bus_oe are 0 and bus_data is all zeros, whatever the control pins do.
- R2: When sel_n, rd_n and hi_byte become all low after any other combination, conv_start is high for exactly one clock cycle. It rises after the third rising clock edge following the change (two synchronizer stages and the state register).
- R3: Holding a low-byte read for any number of cycles produces only the one strobe of R2.
- R4: An access with hi_byte high never raises conv_start.
- R5: With sel_n high, rd_n and hi_byte are ignored: conv_start stays 0 and bus_oe stays 0.
- R6: If conv_busy is high in the cycle the low-byte access is decoded, no strobe is issued for that access, and the read still drives the bus.
- R7: bus_oe is 1 only while both sel_n and rd_n are low after synchronization.
- R8: During a read with hi_byte low, bus_data[7:0] equals result[7:0].
- R9: During a read with hi_byte high, bus_data[7:4] is 0 and bus_data[3:0] equals result[11:8].
- R10: While bus_oe is 1, bus_data[11:8] equals result[11:8], whatever the value of hi_byte.
- R11: While bus_oe is 0, bus_data is all zeros.
- R12: If rd_n and sel_n stay low while hi_byte falls, the resulting low-byte read raises one strobe.
- R13: While a read is enabled, bus_data follows the current contents of result in the same cycle. During a conversion it therefore shows the previous result until the sequencer updates the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low chip select, asynchronous |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| hi_byte | input | 1 | High selects the upper byte lane and blocks starts, asynchronous |
| conv_busy | input | 1 | High while the sequencer is converting |
| result | input | RES_W | Latched result word from the sequencer |
| conv_start | output | 1 | One-cycle conversion request to the sequencer |
| bus_oe | output | 1 | Data bus drive enable |
| bus_data | output | RES_W | Data bus value, zero when not enabled |

## Verification
The bench builds the block with its defaults: a 12-bit result, 8-bit byte lanes and two synchronizer stages. This is small enough to step through all 64 ordered pairs of the eight control pin combinations. For each pair it counts strobe cycles and checks the enable and the lane layout against a different result word. The two-stage setting fixes the strobe at the third edge after a change, so the exact latency is checked directly. The busy case, a long held read, the high-to-low byte change and result updates during a read are each driven separately.

// File: rtl/conv_bus_pkg.sv
package conv_bus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LAUNCH  = 2'd1,
        ST_LO_READ = 2'd2,
        ST_HI_READ = 2'd3
    } acc_state_t;

    typedef struct packed {
        logic active;   // select and read both asserted
        logic upper;    // byte selector high
    } access_t;

endpackage

// File: rtl/conv_bus_sync.sv
module conv_bus_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/conv_bus_decode.sv
module conv_bus_decode
    import conv_bus_pkg::*;
(
    input  logic    sel_n_s,
    input  logic    rd_n_s,
    input  logic    hi_byte_s,
    output access_t acc
);
    always_comb begin
        acc.active = !sel_n_s && !rd_n_s;
        // byte selector only counts when the chip is selected
        acc.upper  = !sel_n_s && hi_byte_s;
    end
endmodule

// File: rtl/conv_bus_fsm.sv
module conv_bus_fsm
    import conv_bus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  access_t acc,
    input  logic    conv_busy,
    output logic    start,
    output logic    drive,
    output logic    upper_lane
);
    acc_state_t state_q, state_d;
    logic lo_req, hi_req;

    assign lo_req = acc.active && !acc.upper;
    assign hi_req = acc.active &&  acc.upper;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_HI_READ: begin
                if (lo_req)      state_d = conv_busy ? ST_LO_READ : ST_LAUNCH;
                else if (hi_req) state_d = ST_HI_READ;
                else             state_d = ST_IDLE;
            end
            ST_LAUNCH, ST_LO_READ: begin
                if (lo_req)      state_d = ST_LO_READ;
                else if (hi_req) state_d = ST_HI_READ;
                else             state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        start      = 1'b0;
        drive      = 1'b0;
        upper_lane = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_LAUNCH:  begin start = 1'b1; drive = 1'b1; end
            ST_LO_READ: drive = 1'b1;
            ST_HI_READ: begin drive = 1'b1; upper_lane = 1'b1; end
        endcase
    end
endmodule

// File: rtl/conv_bus_lanes.sv
module conv_bus_lanes #(
    parameter int RES_W  = 12,
    parameter int BYTE_W = 8
) (
    input  logic             drive,
    input  logic             upper_lane,
    input  logic [RES_W-1:0] result,
    output logic [RES_W-1:0] bus_data
);
    localparam int HI_W  = RES_W - BYTE_W;
    localparam int PAD_W = BYTE_W - HI_W;

    logic [BYTE_W-1:0] low_lane;
    logic [BYTE_W-1:0] packed_hi;

    generate
        if (PAD_W > 0) begin : g_pad
            assign packed_hi = {{PAD_W{1'b0}}, result[RES_W-1:BYTE_W]};
        end else begin : g_nopad
            assign packed_hi = result[RES_W-1:BYTE_W];
        end
    endgenerate

    assign low_lane = upper_lane ? packed_hi : result[BYTE_W-1:0];
    assign bus_data = drive ? {result[RES_W-1:BYTE_W], low_lane} : '0;
endmodule

// File: rtl/conv_bus_if.sv
module conv_bus_if
    import conv_bus_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             rd_n,
    input  logic             hi_byte,
    input  logic             conv_busy,
    input  logic [RES_W-1:0] result,
    output logic             conv_start,
    output logic             bus_oe,
    output logic [RES_W-1:0] bus_data
);
    localparam int CTL_W = 3;
    localparam logic [CTL_W-1:0] CTL_IDLE = 3'b110;

    logic [CTL_W-1:0] ctl_s;
    access_t          acc;
    logic             upper_lane;

    conv_bus_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sel_n, rd_n, hi_byte}),
        .sync_out (ctl_s)
    );

    conv_bus_decode u_dec (
        .sel_n_s   (ctl_s[2]),
        .rd_n_s    (ctl_s[1]),
        .hi_byte_s (ctl_s[0]),
        .acc       (acc)
    );

    conv_bus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .conv_busy  (conv_busy),
        .start      (conv_start),
        .drive      (bus_oe),
        .upper_lane (upper_lane)
    );

    conv_bus_lanes #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_lanes (
        .drive      (bus_oe),
        .upper_lane (upper_lane),
        .result     (result),
        .bus_data   (bus_data)
    );
endmodule

// File: rtl/conv_bus_if_chk.sv
module conv_bus_if_chk #(
    parameter int RES_W  = 12,
    parameter int BYTE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_busy,
    input logic [RES_W-1:0] result,
    input logic             conv_start,
    input logic             bus_oe,
    input logic [RES_W-1:0] bus_data
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R2

    AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !$past(conv_busy)); // R6

    AST_START_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> bus_oe && bus_data[BYTE_W-1:0] == result[BYTE_W-1:0]); // R8

    AST_UPPER_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> bus_data[RES_W-1:BYTE_W] == result[RES_W-1:BYTE_W]); // R10

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_data == '0 && !conv_start); // R11
endmodule

bind conv_bus_if conv_bus_if_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_busy  (conv_busy),
    .result     (result),
    .conv_start (conv_start),
    .bus_oe     (bus_oe),
    .bus_data   (bus_data)
);

// File: tb/sim_conv_bus_if.sv
`timescale 1ns/1ps
module sim_conv_bus_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b0;
    logic        rd_n = 1'b0;
    logic        hi_byte = 1'b0;
    logic        conv_busy = 1'b0;
    logic [11:0] result = 12'hABC;
    logic        conv_start;
    logic        bus_oe;
    logic [11:0] bus_data;

    int n_checks = 0;
    int n_fail   = 0;
    int starts   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) if (conv_start === 1'b1) starts <= starts + 1;

    conv_bus_if u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .hi_byte(hi_byte),
        .conv_busy(conv_busy), .result(result),
        .conv_start(conv_start), .bus_oe(bus_oe), .bus_data(bus_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_ctl(input logic [2:0] v);
        @(negedge clk);
        sel_n = v[2]; rd_n = v[1]; hi_byte = v[0];
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] exp_bus(input logic [2:0] v, input logic [11:0] r);
        if (v[2] || v[1]) return 12'h000;
        if (v[0])         return {r[11:8], 4'h0, r[11:8]};
        return r;
    endfunction

    initial begin
        // R1: pins active during reset must not leak out
        settle(3);
        chk("R1 start in reset", conv_start, 0);
        chk("R1 oe in reset", bus_oe, 0);
        chk("R1 data in reset", bus_data, 0);
        sel_n = 1'b1; rd_n = 1'b1;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 start after reset", conv_start, 0);
        chk("R1 oe after reset", bus_oe, 0);
        settle(4);

        // R2: exact latency of the strobe
        begin
            int s0;
            s0 = starts;
            set_ctl(3'b000);
            settle(2);
            chk("R2 no strobe before third edge", conv_start, 0);
            settle(1);
            chk("R2 strobe after third edge", conv_start, 1);
            settle(1);
            chk("R2 strobe one cycle", conv_start, 0);
            // R3: held read keeps single strobe
            settle(40);
            chk("R3 one strobe for held read", starts - s0, 1);
        end
        set_ctl(3'b110); settle(6);

        // exhaustive pairs of control states
        for (int f = 0; f < 8; f++) begin
            for (int t = 0; t < 8; t++) begin
                int s0;
                logic [11:0] r;
                logic [2:0] fv, tv;
                fv = 3'(f); tv = 3'(t);
                r = 12'((f * 8 + t) * 12'h1D3 + 12'h5A5);
                set_ctl(fv); result = r;
                settle(6);
                s0 = starts;
                set_ctl(tv);
                settle(8);
                if (tv[2])
                    chk("R5 no strobe while deselected", starts - s0, 0);
                else if (fv == 3'b001 && tv == 3'b000)
                    chk("R12 high to low byte strobe", starts - s0, 1);
                else if (tv == 3'b000 && fv != 3'b000)
                    chk("R2 strobe on entry", starts - s0, 1);
                else if (tv == 3'b000)
                    chk("R3 no extra strobe", starts - s0, 0);
                else
                    chk("R4 no strobe without low byte read", starts - s0, 0);
                chk("R7 enable", bus_oe, (!tv[2] && !tv[1]) ? 1 : 0);
                if (tv[2] || tv[1])
                    chk("R11 idle bus zero", bus_data, 0);
                else if (tv[0])
                    chk("R9 R10 high lane", bus_data, exp_bus(tv, r));
                else
                    chk("R8 R10 low lane", bus_data, exp_bus(tv, r));
            end
        end

        // R6: busy suppresses the strobe but not the read
        set_ctl(3'b110); settle(6);
        begin
            int s0;
            conv_busy = 1'b1;
            result = 12'h3C7;
            s0 = starts;
            set_ctl(3'b000);
            settle(8);
            chk("R6 no strobe when busy", starts - s0, 0);
            chk("R6 read still enabled", bus_oe, 1);
            chk("R6 data while busy", bus_data, 12'h3C7);
        end

        // R13: data follows result during an enabled read
        @(negedge clk); result = 12'h81E;
        #1 chk("R13 new result visible", bus_data, 12'h81E);
        set_ctl(3'b001); settle(6);
        @(negedge clk); result = 12'hF42;
        #1 chk("R13 high lane follows", bus_data, 12'hF0F);
        conv_busy = 1'b0;
        set_ctl(3'b110); settle(6);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule